// File: doc/BRIEF.md
# Interleaved Dual-Port Banked Data Memory

This block is a single-cycle on-chip data RAM. It is built from several 32-bit banks and is shared by two 64-bit CPU data ports, A and B. Each port presents a doubleword address. The low address bits choose a pair of adjacent banks and the upper bits choose a row. Consecutive doublewords therefore run across the pairs along one row before moving to the next row. A read or a full-width write takes the even bank and the odd bank of its pair. A write whose byte enables cover only one 32-bit half takes only that half's bank.

When both ports need the same bank in the same cycle, a small arbiter state machine grants one port and raises the other port's stall for that cycle. The stalled port keeps its request on its inputs and retries in the next cycle. The arbiter has two states. PRIO_A lets port A win a collision and PRIO_B lets port B win. In the default alternating policy the arbiter moves from PRIO_A to PRIO_B and back again on every clock edge. In the fixed policy (FIXED_PRIO=1) it stays in PRIO_A. Read data comes back one cycle after the grant, together with a per-port valid flag.

Top module: `ilv_dmem`

## Requirements
- R1: During reset and in the first cycle after it, a_stall, b_stall, a_rvalid and b_rvalid are all 0 while no request is presented.
- R2: A doubleword address splits into a pair index (bits [1:0] with the default 8 banks) and a row (bits [10:2]). Bits 31:0 of the doubleword live in bank 2*pair and bits 63:32 in bank 2*pair+1. Data written through either port reads back unchanged through either port at the same address.
- R3: A granted read (req=1, we=0, stall=0) raises rvalid and returns the addressed doubleword exactly one cycle later. It returns data written in any earlier cycle.
- R4: On a granted write, only the bytes whose be bit is set are updated. be bit i covers wdata bits [8i+7:8i], which gives 8-, 16-, 32- and 64-bit writes.
- R5: If both ports request and need a common bank, exactly one port stalls in that cycle, and the stalled port's access has no effect.
- R6: With the alternating policy, port A wins a collision in cycles 0, 2, 4, … counted from the first cycle after reset, and port B wins in odd cycles. A stalled port that holds its request is granted in the next cycle.
- R7: Accesses that need disjoint banks run in the same cycle with no stall. This covers different pairs in the same row or in different rows, and writes to opposite halves of one pair.
- R8: A write with be=0 needs no bank. It is granted, changes no data and never causes a stall.
- R9: A port that is not requesting never stalls.
- R10: Writes never raise rvalid.
- R11: With the fixed policy (FIXED_PRIO=1), port A never stalls and port B stalls on every collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 11 | Port A doubleword address |
| a_be | input | 8 | Port A byte enables |
| a_wdata | input | 64 | Port A write data |
| a_stall | output | 1 | Port A lost arbitration this cycle |
| a_rvalid | output | 1 | Port A read data valid |
| a_rdata | output | 64 | Port A read data |
| b_req | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | 11 | Port B doubleword address |
| b_be | input | 8 | Port B byte enables |
| b_wdata | input | 64 | Port B write data |
| b_stall | output | 1 | Port B lost arbitration this cycle |
| b_rvalid | output | 1 | Port B read data valid |
| b_rdata | output | 64 | Port B read data |

## Verification
The assertions watch the arbitration and handshake rules on every cycle:

- The two ports never stall together.
- A port stalls only when it is requesting.
- Every granted read yields rvalid one cycle later, and no rvalid appears without such a read.
- Requests to different bank pairs never stall.
- A stalled port is never stalled twice in a row under alternation, or at all as port A under the fixed policy.

Data correctness can only be shown by the bench scenarios, which compare returned data against a reference model. These scenarios cover striping across pairs and rows, byte-lane merging, half-pair writes in parallel, zero-enable writes, and which port a collision favours in a given cycle.

// File: rtl/ilv_dmem_pkg.sv
package ilv_dmem_pkg;
    // Arbitration states: which port wins a bank collision this cycle
    typedef enum logic {
        PRIO_A = 1'b0,
        PRIO_B = 1'b1
    } prio_state_t;
endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map #(
    parameter int NUM_PAIRS = 4,
    parameter int PAIR_W    = 2,
    parameter int ROW_W     = 9,
    parameter int LANE_BE   = 4
) (
    input  logic                       req,
    input  logic                       we,
    input  logic [PAIR_W+ROW_W-1:0]    addr,
    input  logic [2*LANE_BE-1:0]       be,
    output logic [ROW_W-1:0]           row,
    output logic [PAIR_W-1:0]          pair,
    output logic [2*NUM_PAIRS-1:0]     bank_mask
);
    logic need_lo;
    logic need_hi;

    assign pair    = addr[PAIR_W-1:0];
    assign row     = addr[PAIR_W+ROW_W-1:PAIR_W];
    // reads take both halves; writes take only the halves with enabled bytes
    assign need_lo = !we || (|be[0 +: LANE_BE]);
    assign need_hi = !we || (|be[LANE_BE +: LANE_BE]);

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign bank_mask[2*p]   = req && (pair == PAIR_W'(p)) && need_lo;
        assign bank_mask[2*p+1] = req && (pair == PAIR_W'(p)) && need_hi;
    end
endmodule

// File: rtl/ilv_arbiter.sv
module ilv_arbiter
    import ilv_dmem_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter bit FIXED_PRIO = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_a,
    input  logic                 req_b,
    input  logic [NUM_BANKS-1:0] mask_a,
    input  logic [NUM_BANKS-1:0] mask_b,
    output logic                 grant_a,
    output logic                 grant_b,
    output logic                 stall_a,
    output logic                 stall_b
);
    prio_state_t state;
    prio_state_t state_nxt;
    logic        collide;

    // next state: alternate every cycle, or hold PRIO_A in fixed mode
    always_comb begin
        unique case (state)
            PRIO_A:  state_nxt = FIXED_PRIO ? PRIO_A : PRIO_B;
            PRIO_B:  state_nxt = PRIO_A;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PRIO_A;
        else        state <= state_nxt;
    end

    // outputs
    always_comb begin
        collide = req_a && req_b && (|(mask_a & mask_b));
        grant_a = 1'b0;
        grant_b = 1'b0;
        unique case (state)
            PRIO_A: begin
                grant_a = req_a;
                grant_b = req_b && !collide;
            end
            PRIO_B: begin
                grant_a = req_a && !collide;
                grant_b = req_b;
            end
        endcase
        stall_a = req_a && !grant_a;
        stall_b = req_b && !grant_b;
    end
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int DEPTH  = 512,
    parameter int LANE_W = 32,
    localparam int ROW_W = $clog2(DEPTH),
    localparam int NBYTE = LANE_W / 8
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [NBYTE-1:0]  be,
    input  logic [ROW_W-1:0]  row,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int i = 0; i < NBYTE; i++) begin
                if (be[i]) mem[row][i*8 +: 8] <= wdata[i*8 +: 8];
            end
        end
        if (en && !we) rdata <= mem[row];
    end
endmodule

// File: rtl/ilv_dmem.sv
module ilv_dmem
    import ilv_dmem_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int BANK_DEPTH = 512,
    parameter int LANE_W     = 32,
    parameter bit FIXED_PRIO = 1'b0,
    localparam int NUM_PAIRS = NUM_BANKS / 2,
    localparam int PAIR_W    = $clog2(NUM_PAIRS),
    localparam int ROW_W     = $clog2(BANK_DEPTH),
    localparam int ADDR_W    = PAIR_W + ROW_W,
    localparam int DATA_W    = 2 * LANE_W,
    localparam int LANE_BE   = LANE_W / 8,
    localparam int BE_W      = 2 * LANE_BE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [BE_W-1:0]   a_be,
    input  logic [DATA_W-1:0] a_wdata,
    output logic              a_stall,
    output logic              a_rvalid,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_req,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [BE_W-1:0]   b_be,
    input  logic [DATA_W-1:0] b_wdata,
    output logic              b_stall,
    output logic              b_rvalid,
    output logic [DATA_W-1:0] b_rdata
);
    logic [ROW_W-1:0]     row_a, row_b;
    logic [PAIR_W-1:0]    pair_a, pair_b;
    logic [PAIR_W-1:0]    pair_a_q, pair_b_q;
    logic [NUM_BANKS-1:0] mask_a, mask_b;
    logic                 grant_a, grant_b;
    logic [LANE_W-1:0]    bank_rd [NUM_BANKS];

    ilv_addr_map #(
        .NUM_PAIRS(NUM_PAIRS), .PAIR_W(PAIR_W), .ROW_W(ROW_W), .LANE_BE(LANE_BE)
    ) u_map_a (
        .req(a_req), .we(a_we), .addr(a_addr), .be(a_be),
        .row(row_a), .pair(pair_a), .bank_mask(mask_a)
    );

    ilv_addr_map #(
        .NUM_PAIRS(NUM_PAIRS), .PAIR_W(PAIR_W), .ROW_W(ROW_W), .LANE_BE(LANE_BE)
    ) u_map_b (
        .req(b_req), .we(b_we), .addr(b_addr), .be(b_be),
        .row(row_b), .pair(pair_b), .bank_mask(mask_b)
    );

    ilv_arbiter #(
        .NUM_BANKS(NUM_BANKS), .FIXED_PRIO(FIXED_PRIO)
    ) u_arb (
        .clk(clk), .rst_n(rst_n),
        .req_a(a_req), .req_b(b_req),
        .mask_a(mask_a), .mask_b(mask_b),
        .grant_a(grant_a), .grant_b(grant_b),
        .stall_a(a_stall), .stall_b(b_stall)
    );

    // one bank per lane; the granted owner of each bank drives its inputs
    for (genvar j = 0; j < NUM_BANKS; j++) begin : g_bank
        localparam int HALF = j % 2;
        logic sel_a;
        logic sel_b;
        assign sel_a = grant_a && mask_a[j];
        assign sel_b = grant_b && mask_b[j];

        ilv_bank #(.DEPTH(BANK_DEPTH), .LANE_W(LANE_W)) u_bank (
            .clk  (clk),
            .en   (sel_a || sel_b),
            .we   (sel_a ? a_we : b_we),
            .be   (sel_a ? a_be[HALF*LANE_BE +: LANE_BE] : b_be[HALF*LANE_BE +: LANE_BE]),
            .row  (sel_a ? row_a : row_b),
            .wdata(sel_a ? a_wdata[HALF*LANE_W +: LANE_W] : b_wdata[HALF*LANE_W +: LANE_W]),
            .rdata(bank_rd[j])
        );
    end

    // read return tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rvalid <= 1'b0;
            b_rvalid <= 1'b0;
            pair_a_q <= '0;
            pair_b_q <= '0;
        end else begin
            a_rvalid <= grant_a && !a_we;
            b_rvalid <= grant_b && !b_we;
            pair_a_q <= pair_a;
            pair_b_q <= pair_b;
        end
    end

    always_comb begin
        a_rdata = '0;
        b_rdata = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (pair_a_q == p[PAIR_W-1:0]) a_rdata = {bank_rd[2*p+1], bank_rd[2*p]};
            if (pair_b_q == p[PAIR_W-1:0]) b_rdata = {bank_rd[2*p+1], bank_rd[2*p]};
        end
    end
endmodule

// File: rtl/ilv_dmem_chk.sv
module ilv_dmem_chk #(
    parameter int PAIR_W     = 2,
    parameter bit FIXED_PRIO = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_req,
    input logic              a_we,
    input logic [PAIR_W-1:0] a_pair,
    input logic              a_stall,
    input logic              a_rvalid,
    input logic              b_req,
    input logic              b_we,
    input logic [PAIR_W-1:0] b_pair,
    input logic              b_stall,
    input logic              b_rvalid
);
    assert_single_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_stall && b_stall));

    assert_stall_needs_req_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        a_stall |-> a_req);
    assert_stall_needs_req_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        b_stall |-> b_req);

    assert_read_latency_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && !a_we && !a_stall) |=> a_rvalid);
    assert_read_latency_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && !b_we && !b_stall) |=> b_rvalid);

    assert_no_stray_rvalid_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        a_rvalid |-> $past(a_req && !a_we && !a_stall));
    assert_no_stray_rvalid_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
        b_rvalid |-> $past(b_req && !b_we && !b_stall));

    assert_retry_wins_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!FIXED_PRIO && a_stall) |=> !a_stall);
    assert_retry_wins_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!FIXED_PRIO && b_stall) |=> !b_stall);

    assert_fixed_a_never_stalls_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (FIXED_PRIO && a_req) |-> !a_stall);

    assert_distinct_pairs_parallel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && b_req && (a_pair != b_pair)) |-> (!a_stall && !b_stall));
endmodule

bind ilv_dmem ilv_dmem_chk #(.PAIR_W(PAIR_W), .FIXED_PRIO(FIXED_PRIO)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_we(a_we), .a_pair(a_addr[PAIR_W-1:0]),
    .a_stall(a_stall), .a_rvalid(a_rvalid),
    .b_req(b_req), .b_we(b_we), .b_pair(b_addr[PAIR_W-1:0]),
    .b_stall(b_stall), .b_rvalid(b_rvalid)
);

// File: tb/tb_ilv_dmem.sv
module tb_ilv_dmem;
    typedef struct packed {
        logic        req;
        logic        we;
        logic [10:0] addr;
        logic [7:0]  be;
        logic [63:0] wd;
    } stim_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    stim_t sa, sb;
    logic a_stall, a_rvalid, b_stall, b_rvalid;
    logic [63:0] a_rdata, b_rdata;
    logic fa_stall, fa_rvalid, fb_stall, fb_rvalid;
    logic [63:0] fa_rdata, fb_rdata;

    ilv_dmem dut (
        .clk(clk), .rst_n(rst_n),
        .a_req(sa.req), .a_we(sa.we), .a_addr(sa.addr), .a_be(sa.be), .a_wdata(sa.wd),
        .a_stall(a_stall), .a_rvalid(a_rvalid), .a_rdata(a_rdata),
        .b_req(sb.req), .b_we(sb.we), .b_addr(sb.addr), .b_be(sb.be), .b_wdata(sb.wd),
        .b_stall(b_stall), .b_rvalid(b_rvalid), .b_rdata(b_rdata)
    );

    ilv_dmem #(.FIXED_PRIO(1'b1)) dut_fix (
        .clk(clk), .rst_n(rst_n),
        .a_req(sa.req), .a_we(sa.we), .a_addr(sa.addr), .a_be(sa.be), .a_wdata(sa.wd),
        .a_stall(fa_stall), .a_rvalid(fa_rvalid), .a_rdata(fa_rdata),
        .b_req(sb.req), .b_we(sb.we), .b_addr(sb.addr), .b_be(sb.be), .b_wdata(sb.wd),
        .b_stall(fb_stall), .b_rvalid(fb_rvalid), .b_rdata(fb_rdata)
    );

    int checks = 0;
    int failures = 0;
    logic finished = 1'b0;
    logic exp_prio_a;
    logic [63:0] model [int];
    logic [63:0] qa [$];
    logic [63:0] qb [$];

    // cycle parity since reset: A favoured in even cycles (R6)
    always_ff @(posedge clk) begin
        if (!rst_n) exp_prio_a <= 1'b1;
        else        exp_prio_a <= !exp_prio_a;
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic stim_t idle();
        stim_t s;
        s = '0;
        return s;
    endfunction

    function automatic stim_t rd(input logic [10:0] a);
        stim_t s;
        s = '0; s.req = 1'b1; s.addr = a;
        return s;
    endfunction

    function automatic stim_t wr(input logic [10:0] a, input logic [7:0] be, input logic [63:0] d);
        stim_t s;
        s.req = 1'b1; s.we = 1'b1; s.addr = a; s.be = be; s.wd = d;
        return s;
    endfunction

    // banks needed: pair = addr[1:0]; low half bank 2*pair, high half 2*pair+1 (R2)
    function automatic logic [7:0] need(input stim_t s);
        logic [7:0] m;
        int p;
        m = '0;
        p = int'(s.addr[1:0]);
        if (s.req) begin
            m[2*p]   = !s.we || (|s.be[3:0]);
            m[2*p+1] = !s.we || (|s.be[7:4]);
        end
        return m;
    endfunction

    // scoreboard monitor: read data due one cycle after grant (R3), none for writes (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (a_rvalid) begin
                if (qa.size() == 0) check(1'b0, "R10 port A unexpected rvalid", 64'd1, 64'd0);
                else begin
                    logic [63:0] e;
                    e = qa.pop_front();
                    check(a_rdata == e, "R3 port A read data", a_rdata, e);
                end
            end else if (qa.size() != 0) begin
                check(1'b0, "R3 port A rvalid missing", 64'd0, 64'd1);
                void'(qa.pop_front());
            end
            if (b_rvalid) begin
                if (qb.size() == 0) check(1'b0, "R10 port B unexpected rvalid", 64'd1, 64'd0);
                else begin
                    logic [63:0] e;
                    e = qb.pop_front();
                    check(b_rdata == e, "R3 port B read data", b_rdata, e);
                end
            end else if (qb.size() != 0) begin
                check(1'b0, "R3 port B rvalid missing", 64'd0, 64'd1);
                void'(qb.pop_front());
            end
        end
    end

    function automatic logic [63:0] merge(input logic [63:0] old, input stim_t s);
        logic [63:0] r;
        r = old;
        for (int i = 0; i < 8; i++) if (s.be[i]) r[i*8 +: 8] = s.wd[i*8 +: 8];
        return r;
    endfunction

    // driver: one cycle of stimulus, check stalls, push expected reads
    task automatic step(input stim_t a, input stim_t b);
        logic [7:0] ma, mb;
        logic col, ga, gb;
        @(negedge clk);
        sa = a; sb = b;
        #1;
        ma = need(a); mb = need(b);
        col = a.req && b.req && (|(ma & mb));
        ga = a.req && (!col || exp_prio_a);
        gb = b.req && (!col || !exp_prio_a);
        check(a_stall == (a.req && !ga), "R5/R6/R7/R8/R9 stall_a", {63'd0, a_stall}, {63'd0, a.req && !ga});
        check(b_stall == (b.req && !gb), "R5/R6/R7/R8/R9 stall_b", {63'd0, b_stall}, {63'd0, b.req && !gb});
        check(fa_stall == 1'b0, "R11 fixed stall_a", {63'd0, fa_stall}, 64'd0);
        check(fb_stall == (b.req && col), "R11 fixed stall_b", {63'd0, fb_stall}, {63'd0, b.req && col});
        if (ga && !a.we) qa.push_back(model.exists(int'(a.addr)) ? model[int'(a.addr)] : 64'd0);
        if (gb && !b.we) qb.push_back(model.exists(int'(b.addr)) ? model[int'(b.addr)] : 64'd0);
        if (ga && a.we) model[int'(a.addr)] = merge(model.exists(int'(a.addr)) ? model[int'(a.addr)] : 64'd0, a);
        if (gb && b.we) model[int'(b.addr)] = merge(model.exists(int'(b.addr)) ? model[int'(b.addr)] : 64'd0, b);
    endtask

    // issue a pair of requests, holding each stalled one until it is granted (R6)
    task automatic both(input stim_t a, input stim_t b);
        stim_t ca, cb;
        ca = a; cb = b;
        for (int n = 0; n < 4 && (ca.req || cb.req); n++) begin
            step(ca, cb);
            if (!a_stall) ca = idle();
            if (!b_stall) cb = idle();
        end
        check(!ca.req && !cb.req, "R6 held request granted next cycle", {63'd0, ca.req | cb.req}, 64'd0);
    endtask

    initial begin
        sa = idle(); sb = idle();
        repeat (3) @(posedge clk);
        check(!a_stall && !b_stall && !a_rvalid && !b_rvalid, "R1 outputs in reset",
              {60'd0, a_stall, b_stall, a_rvalid, b_rvalid}, 64'd0);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check(!a_stall && !b_stall && !a_rvalid && !b_rvalid, "R1 outputs after reset",
              {60'd0, a_stall, b_stall, a_rvalid, b_rvalid}, 64'd0);

        // striped fill: whole rows through both ports, different pairs in parallel (R2, R7)
        for (int r = 0; r < 3; r++) begin
            for (int p = 0; p < 4; p += 2) begin
                both(wr(11'((r << 2) + p), 8'hFF, {32'hA000 + 32'(r), 32'hB000 + 32'(p)}),
                     wr(11'((r << 2) + p + 1), 8'hFF, {32'hC000 + 32'(r), 32'hD000 + 32'(p)}));
            end
        end
        // same row, different pair; read back crosswise (R2, R3, R7)
        both(rd(11'h005), rd(11'h004));
        both(rd(11'h000), rd(11'h00B));
        // same pair, different rows: collision in both parities (R5, R6)
        both(rd(11'h001), rd(11'h009));
        step(idle(), idle());
        both(rd(11'h001), rd(11'h009));
        both(wr(11'h002, 8'hFF, 64'h1111_2222_3333_4444), rd(11'h00A));
        both(rd(11'h002), wr(11'h006, 8'hFF, 64'h5555_6666_7777_8888));
        both(rd(11'h006), rd(11'h002));
        // byte-enable widths (R4)
        both(wr(11'h100, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF), idle());
        both(wr(11'h100, 8'h01, 64'h0000_0000_0000_0012), idle());
        both(wr(11'h100, 8'h0C, 64'h0000_0000_3456_0000), idle());
        both(wr(11'h100, 8'hF0, 64'h789A_BCDE_0000_0000), rd(11'h101));
        both(rd(11'h100), idle());
        // opposite halves of one pair written in parallel (R7)
        both(wr(11'h203, 8'h0F, 64'hDEAD_DEAD_0BAD_F00D), wr(11'h203, 8'hF0, 64'hCAFE_BABE_1234_5678));
        both(rd(11'h203), idle());
        // overlapping half writes collide (R5)
        both(wr(11'h203, 8'h30, 64'h0000_AA00_0000_0000), wr(11'h203, 8'h60, 64'h0055_5500_0000_0000));
        both(idle(), rd(11'h203));
        // zero-enable write: no stall, no change (R8)
        both(wr(11'h100, 8'h00, 64'h0), rd(11'h100));
        both(rd(11'h100), wr(11'h104, 8'h00, 64'h5A5A));
        both(rd(11'h104), idle());
        // back-to-back collisions on one pair across parities (R6)
        for (int k = 0; k < 5; k++) both(rd(11'h004), rd(11'h000));
        step(idle(), idle());
        step(idle(), idle());
        check(qa.size() == 0 && qb.size() == 0, "R3 all reads returned",
              64'(qa.size() + qb.size()), 64'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule